// File: doc/BRIEF.md
# RMII 10 Mb/s Dibit Interface (PHY Side)

This block sits in a physical-layer device between the Reduced MII pins and the 10 Mb/s data path. A single 50 MHz reference clock times everything. At 10 Mb/s the controller holds each 2-bit value for ten reference clocks.

In the transmit direction the block samples the transmit dibit once per ten-clock window while the transmit enable is high. It packs each pair of accepted dibits into a 4-bit nibble, which it presents with a one-cycle strobe. Data on the dibit pins while enable is low is treated as idle or reserved signalling and never reaches the nibble path. If enable drops after an odd number of dibits, the half-built nibble is dropped and a framing-error pulse is raised.

In the receive direction the receive path hands over nibbles with a one-cycle valid. The block sends each nibble to the controller as two dibits, low half first, each held for ten clocks. The receive pins change on the falling clock edge, because the controller samples them on the rising edge. When nothing is being sent, the pins sit at zero.

Top module: `rmii10_phy_dibit`

## Requirements
- R1: While reset is high, and after a rising clock edge with reset high, `tx_nibble` is 0, `tx_nibble_vld` and `tx_frame_err` are 0, and `rx_dibit` is 2'b00.
- R2: The first transmit dibit is sampled on the rising edge at which `tx_enable` is first seen high. While enable stays high, a new dibit is sampled every DIV rising edges after that one. Values present between sample edges have no effect.
- R3: Of two consecutive accepted dibits, the first lands in `tx_nibble[1:0]` and the second in `tx_nibble[3:2]`. `tx_nibble_vld` is high for exactly one cycle, on the cycle after the second dibit's sample edge. `tx_nibble` keeps its value until the next strobe.
- R4: Any `tx_dibit` value, including nonzero reserved codes, applied while `tx_enable` is low causes no strobe and no framing error. It changes neither `tx_nibble` nor the pairing of the next frame's dibits.
- R5: When `tx_enable` falls after an odd number of accepted dibits, `tx_frame_err` pulses for one cycle, on the cycle after the first edge with enable low, and the partial nibble is discarded. A fall after an even count gives no pulse. The next frame's first dibit again lands in bits [1:0].
- R6: The sample window realigns on each rise of `tx_enable`, whatever the phase of the divider when enable fell.
- R7: A nibble accepted on a rising edge with `rx_nibble_vld` high appears as `rx_nibble[1:0]` on `rx_dibit` from the next falling edge for DIV clocks, then as `rx_nibble[3:2]` for DIV clocks.
- R8: `rx_dibit` changes only on falling clock edges.
- R9: While no received nibble is in progress, `rx_dibit` is 2'b00.
- R10: A receive nibble offered on the last clock of the current nibble follows it with no idle gap. A nibble offered on any other clock while one is in progress is dropped and does not change `rx_dibit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Transmit enable from the controller |
| tx_dibit | input | 2 | Transmit dibit from the controller |
| tx_nibble | output | 4 | Packed transmit nibble |
| tx_nibble_vld | output | 1 | One-cycle strobe marking a new nibble |
| tx_frame_err | output | 1 | One-cycle pulse: enable fell on an odd dibit |
| rx_nibble | input | 4 | Nibble from the receive path |
| rx_nibble_vld | input | 1 | One-cycle valid for `rx_nibble` |
| rx_dibit | output | 2 | Receive dibit to the controller, falling-edge launched |

## Verification
The bench builds the block with DIV set to 4, so a dibit window is four clocks and a receive nibble is eight. This keeps every window short while still placing glitch values strictly between sample edges. It also puts the re-raise of enable (three clocks after a fall) out of step with the divider, and leaves room for an offered nibble to land both mid-nibble and on the final cycle of a nibble. The RTL is elaborated at the default of ten as well, so the counter widths for the real rate are covered.

// File: rtl/rmii10_pkg.sv
`timescale 1ns/1ps
package rmii10_pkg;
    localparam int DIBIT_W = 2;
    localparam int NIB_W   = 2 * DIBIT_W;

    typedef logic [DIBIT_W-1:0] dibit_t;
    typedef logic [NIB_W-1:0]   nibble_t;
endpackage

// File: rtl/rmii10_window.sv
`timescale 1ns/1ps
// Sample-window generator: one tick per DIV clocks while enable is high,
// with the first tick on the clock where enable rises.
module rmii10_window #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick,
    output logic en_fall
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          en;
    } win_t;

    win_t win_q, win_d;
    logic rise;
    logic wrap;

    always_comb begin
        rise    = en && !win_q.en;
        en_fall = !en && win_q.en;
        wrap    = (win_q.cnt == LAST);
        tick    = en && (rise || wrap);

        win_d.en  = en;
        win_d.cnt = (rise || wrap) ? '0 : win_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) win_q <= '0;
        else     win_q <= win_d;
    end

    AST_WIN_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        win_q.cnt <= LAST); // R2

    AST_WIN_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (en && !win_q.en) |=> (win_q.cnt == '0)); // R6
endmodule

// File: rtl/rmii10_tx_pack.sv
`timescale 1ns/1ps
// Transmit packer: pairs accepted dibits into nibbles, low half first.
module rmii10_tx_pack
    import rmii10_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    en_fall,
    input  dibit_t  dibit_in,
    output nibble_t nib,
    output logic    nib_vld,
    output logic    ferr
);
    typedef struct packed {
        dibit_t  lo;
        logic    half;
        nibble_t nib;
        logic    vld;
        logic    ferr;
    } pk_t;

    pk_t pk_q, pk_d;

    always_comb begin
        pk_d      = pk_q;
        pk_d.vld  = 1'b0;
        pk_d.ferr = 1'b0;
        if (tick) begin
            if (!pk_q.half) begin
                pk_d.lo   = dibit_in;
                pk_d.half = 1'b1;
            end else begin
                pk_d.nib  = {dibit_in, pk_q.lo};
                pk_d.vld  = 1'b1;
                pk_d.half = 1'b0;
            end
        end else if (en_fall) begin
            pk_d.ferr = pk_q.half;
            pk_d.half = 1'b0;
            pk_d.lo   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pk_q <= '0;
        else     pk_q <= pk_d;
    end

    assign nib     = pk_q.nib;
    assign nib_vld = pk_q.vld;
    assign ferr    = pk_q.ferr;

    AST_NO_STROBE_AND_ERR: assert property (@(posedge clk) disable iff (rst)
        !(pk_q.vld && pk_q.ferr)); // R5

    AST_HALF_CLEARED_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        en_fall |=> !pk_q.half); // R5
endmodule

// File: rtl/rmii10_rx_split.sv
`timescale 1ns/1ps
// Receive splitter: sends a nibble as two dibits, each held DIV clocks,
// launched on the falling edge.
module rmii10_rx_split
    import rmii10_pkg::*;
#(
    parameter int DIV = 10
) (
    input  logic    clk,
    input  logic    rst,
    input  nibble_t nib_in,
    input  logic    nib_vld,
    output dibit_t  dibit_out
);
    localparam int SPAN = 2 * DIV;
    localparam int CW   = $clog2(SPAN);
    localparam logic [CW-1:0] LAST = CW'(SPAN - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        nibble_t       nib;
    } sp_t;

    sp_t    sp_q, sp_d;
    logic   take;
    dibit_t cur;
    dibit_t out_q;

    always_comb begin
        take = nib_vld && (!sp_q.busy || sp_q.cnt == LAST);
        sp_d = sp_q;
        if (take) begin
            sp_d.busy = 1'b1;
            sp_d.cnt  = '0;
            sp_d.nib  = nib_in;
        end else if (sp_q.busy) begin
            if (sp_q.cnt == LAST) begin
                sp_d.busy = 1'b0;
                sp_d.cnt  = '0;
                sp_d.nib  = '0;
            end else begin
                sp_d.cnt = sp_q.cnt + 1'b1;
            end
        end

        if (!sp_q.busy)            cur = '0;
        else if (sp_q.cnt < HALF)  cur = sp_q.nib[DIBIT_W-1:0];
        else                       cur = sp_q.nib[NIB_W-1:DIBIT_W];
    end

    always_ff @(posedge clk) begin
        if (rst) sp_q <= '0;
        else     sp_q <= sp_d;
    end

    always_ff @(negedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= cur;
    end

    assign dibit_out = out_q;

    AST_RX_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        sp_q.cnt <= LAST); // R7

    AST_RX_LOAD: assert property (@(posedge clk) disable iff (rst)
        (nib_vld && !sp_q.busy) |=> (sp_q.busy && sp_q.cnt == '0)); // R7

    AST_RX_IDLE_OUT: assert property (@(posedge clk) disable iff (rst)
        !sp_q.busy |-> (dibit_out == '0)); // R9
endmodule

// File: rtl/rmii10_phy_dibit.sv
`timescale 1ns/1ps
module rmii10_phy_dibit
    import rmii10_pkg::*;
#(
    parameter int DIV = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_enable,
    input  logic [1:0]       tx_dibit,
    output logic [3:0]       tx_nibble,
    output logic             tx_nibble_vld,
    output logic             tx_frame_err,
    input  logic [3:0]       rx_nibble,
    input  logic             rx_nibble_vld,
    output logic [1:0]       rx_dibit
);
    logic tick;
    logic en_fall;

    rmii10_window #(.DIV(DIV)) u_window (
        .clk     (clk),
        .rst     (rst),
        .en      (tx_enable),
        .tick    (tick),
        .en_fall (en_fall)
    );

    rmii10_tx_pack u_pack (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .en_fall  (en_fall),
        .dibit_in (tx_dibit),
        .nib      (tx_nibble),
        .nib_vld  (tx_nibble_vld),
        .ferr     (tx_frame_err)
    );

    rmii10_rx_split #(.DIV(DIV)) u_split (
        .clk       (clk),
        .rst       (rst),
        .nib_in    (rx_nibble),
        .nib_vld   (rx_nibble_vld),
        .dibit_out (rx_dibit)
    );

    AST_NO_IDLE_STROBE: assert property (@(posedge clk) disable iff (rst)
        tx_nibble_vld |-> $past(tx_enable)); // R4

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
        tx_nibble_vld |=> !tx_nibble_vld); // R3

    AST_NIBBLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tx_nibble_vld |-> $stable(tx_nibble)); // R3

    AST_FERR_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        tx_frame_err |-> ($past(tx_enable, 2) && !$past(tx_enable))); // R5
endmodule

// File: tb/rmii10_phy_dibit_tb.sv
`timescale 1ns/1ps
module rmii10_phy_dibit_tb;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_enable = 1'b0;
    logic [1:0] tx_dibit = 2'b00;
    logic [3:0] tx_nibble;
    logic       tx_nibble_vld;
    logic       tx_frame_err;
    logic [3:0] rx_nibble = 4'h0;
    logic       rx_nibble_vld = 1'b0;
    logic [1:0] rx_dibit;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;

    logic [3:0] nib_log [0:63];
    int log_n = 0;
    int ferr_n = 0;
    int edge_viol = 0;
    logic [1:0] rx_pre = 2'b00;

    rmii10_phy_dibit #(.DIV(DIV)) u_dut (
        .clk(clk), .rst(rst),
        .tx_enable(tx_enable), .tx_dibit(tx_dibit),
        .tx_nibble(tx_nibble), .tx_nibble_vld(tx_nibble_vld),
        .tx_frame_err(tx_frame_err),
        .rx_nibble(rx_nibble), .rx_nibble_vld(rx_nibble_vld),
        .rx_dibit(rx_dibit)
    );

    always #2 clk = ~clk;

    // Monitor: sampled 1 ns after the falling edge.
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (tx_nibble_vld && log_n < 64) begin
                nib_log[log_n] = tx_nibble;
                log_n++;
            end
            if (tx_frame_err) ferr_n++;
        end
        rx_pre = rx_dibit;
    end

    // R8: the receive dibit must not move at the rising edge.
    always @(posedge clk) begin
        #1;
        if (!rst && rx_dibit !== rx_pre) edge_viol++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic drive_dibit(input logic [1:0] d, input int cycles);
        tx_enable = 1'b1;
        tx_dibit  = d;
        step(cycles);
    endtask

    task automatic end_frame(input int idle);
        tx_enable = 1'b0;
        tx_dibit  = 2'b00;
        step(idle);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        step(3);
        check(tx_nibble == 4'h0, "R1 tx_nibble", tx_nibble, 0);
        check(tx_nibble_vld == 1'b0, "R1 tx_nibble_vld", tx_nibble_vld, 0);
        check(tx_frame_err == 1'b0, "R1 tx_frame_err", tx_frame_err, 0);
        check(rx_dibit == 2'b00, "R1 rx_dibit", rx_dibit, 0);
        rst = 1'b0;
        step(2);
    endtask

    task automatic test_pack();
        int b = log_n;
        int f = ferr_n;
        drive_dibit(2'b01, DIV);
        drive_dibit(2'b10, DIV);
        drive_dibit(2'b11, DIV);
        drive_dibit(2'b00, DIV);
        end_frame(3);
        check(log_n == b + 2, "R3 strobe count", log_n - b, 2);
        check(nib_log[b] == 4'h9, "R3 first nibble", nib_log[b], 9);
        check(nib_log[b+1] == 4'h3, "R3 second nibble", nib_log[b+1], 3);
        check(tx_nibble == 4'h3, "R3 nibble held", tx_nibble, 3);
        check(ferr_n == f, "R5 even fall no error", ferr_n - f, 0);
    endtask

    task automatic test_ignore_idle();
        int b = log_n;
        int f = ferr_n;
        tx_enable = 1'b0;
        tx_dibit = 2'b11; step(13);
        tx_dibit = 2'b01; step(7);
        tx_dibit = 2'b10; step(9);
        tx_dibit = 2'b00; step(1);
        check(log_n == b, "R4 no strobe while idle", log_n - b, 0);
        check(ferr_n == f, "R4 no error while idle", ferr_n - f, 0);
        check(tx_nibble == 4'h3, "R4 nibble unchanged", tx_nibble, 3);
        drive_dibit(2'b10, DIV);
        drive_dibit(2'b01, DIV);
        end_frame(3);
        check(log_n == b + 1 && nib_log[b] == 4'h6, "R4 pairing unaffected",
              nib_log[b], 6);
    endtask

    task automatic test_odd_fall();
        int b = log_n;
        int f = ferr_n;
        drive_dibit(2'b11, DIV);
        drive_dibit(2'b01, DIV);
        drive_dibit(2'b10, DIV);
        end_frame(3);
        check(log_n == b + 1 && nib_log[b] == 4'h7, "R5 complete nibble kept",
              nib_log[b], 7);
        check(ferr_n == f + 1, "R5 error pulse count", ferr_n - f, 1);
        check(tx_nibble == 4'h7, "R5 partial discarded", tx_nibble, 7);
        drive_dibit(2'b00, DIV);
        drive_dibit(2'b01, DIV);
        end_frame(3);
        check(log_n == b + 2 && nib_log[b+1] == 4'h4, "R5 fresh pairing",
              nib_log[b+1], 4);
        check(ferr_n == f + 1, "R5 no extra error", ferr_n - f, 1);
    endtask

    task automatic test_window_realign();
        int b = log_n;
        // R2: only values on the sample edges count.
        drive_dibit(2'b10, 1);
        drive_dibit(2'b01, DIV - 1);
        drive_dibit(2'b11, 1);
        drive_dibit(2'b00, DIV - 1);
        end_frame(3);
        check(log_n == b + 1 && nib_log[b] == 4'hE, "R2 sample points",
              nib_log[b], 14);
        // R6: re-raise out of step with the divider.
        drive_dibit(2'b01, 1);
        drive_dibit(2'b11, DIV - 1);
        drive_dibit(2'b00, 1);
        drive_dibit(2'b10, DIV - 1);
        end_frame(5);
        check(log_n == b + 2 && nib_log[b+1] == 4'h1, "R6 realign on rise",
              nib_log[b+1], 1);
    endtask

    // Send nibbles back-to-back (R7, R10), then check idle (R9).
    task automatic test_rx_stream();
        logic [3:0] seq [0:2];
        seq[0] = 4'hB; seq[1] = 4'h6; seq[2] = 4'hD;
        check(rx_dibit == 2'b00, "R9 idle before stream", rx_dibit, 0);
        rx_nibble = seq[0];
        rx_nibble_vld = 1'b1;
        step(1);
        rx_nibble_vld = 1'b0;
        for (int k = 0; k < 3; k++) begin
            for (int j = 1; j <= 2 * DIV; j++) begin
                logic [1:0] e;
                e = (j <= DIV) ? seq[k][1:0] : seq[k][3:2];
                check(rx_dibit == e, (k == 0) ? "R7 dibit order" : "R10 seamless follow",
                      rx_dibit, e);
                if (j == 2 * DIV && k < 2) begin
                    rx_nibble = seq[k+1];
                    rx_nibble_vld = 1'b1;
                end
                step(1);
                rx_nibble_vld = 1'b0;
            end
        end
        for (int j = 0; j < 3; j++) begin
            check(rx_dibit == 2'b00, "R9 idle after stream", rx_dibit, 0);
            step(1);
        end
    endtask

    task automatic test_rx_drop();
        rx_nibble = 4'h9;
        rx_nibble_vld = 1'b1;
        step(1);
        rx_nibble_vld = 1'b0;
        for (int j = 1; j <= 2 * DIV; j++) begin
            logic [1:0] e;
            e = (j <= DIV) ? 2'b01 : 2'b10;
            check(rx_dibit == e, "R10 mid-nibble offer dropped", rx_dibit, e);
            if (j == 3) begin
                rx_nibble = 4'hF;
                rx_nibble_vld = 1'b1;
            end
            step(1);
            rx_nibble_vld = 1'b0;
        end
        for (int j = 0; j < 2 * DIV; j++) begin
            check(rx_dibit == 2'b00, "R9 idle after dropped offer", rx_dibit, 0);
            step(1);
        end
    endtask

    initial begin
        step(1);
        test_reset();
        test_pack();
        test_ignore_idle();
        test_odd_fall();
        test_window_realign();
        test_rx_stream();
        test_rx_drop();
        check(edge_viol == 0, "R8 rx_dibit moved at rising edge", edge_viol, 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule